// File: doc/BRIEF.md
# Window/Timeout Watchdog Supervisor

This block watches a host controller through a software watchdog and owns the host's active-low reset line. The host arms and services the watchdog through a single register write port. Every write both loads a three-bit configuration word and counts as a service attempt. In window operation each period is divided into a closed half, where a service attempt counts as a fault, and an open half, where it restarts the period. In timeout operation any service before the end of the period restarts it. Time is counted in ticks of an external millisecond strobe.

Two reset behaviours are chosen by a strap input that is sampled while the synchronous reset is high. In the first, an unserviced period pulses the reset output low for a fixed number of ticks. In the second, the reset output is left alone and a separate status output drops and stays low until a valid service arrives. A supply-good input overrides both behaviours. While the supply is low, reset is held low. Once the supply is good again, reset is stretched for the same fixed number of ticks before it is released.

Top module: `wdg_supervisor`

## Requirements
- R1: Synchronous reset drives `rst_n_o` low and `wd_ok_o` high, and it restores the configuration to window operation with period code 0.
- R2: `wr_data[1:0]` is the period code. Codes 0, 1, 2 and 3 select 10, 45, 100 and 350 ticks. With no valid service, `rst_n_o` stays high for exactly that many ticks after counting starts.
- R3: When `wr_data[2]` is 1 the watchdog runs in timeout operation. A write at any count, including the first and the last tick of the period, restarts the period.
- R4: When `wr_data[2]` is 0 (window operation) the first floor(P/2) ticks of the period form the closed window. A write there drops `rst_n_o` in the next cycle, in either reset behaviour.
- R5: In window operation a write in the open window, from tick floor(P/2) up to and including tick P-1, keeps `rst_n_o` high, sets `wd_ok_o` high and restarts the period with the newly written configuration.
- R6: In reset behaviour 1 an expired period, or a closed-window write, holds `rst_n_o` low for exactly RST_DUR ticks. Counting then restarts at zero in the closed window.
- R7: In reset behaviour 2 an expired period leaves `rst_n_o` high, drops `wd_ok_o` and restarts the period. `wd_ok_o` stays low across further expiries until a valid service.
- R8: While `supply_ok` is low, `rst_n_o` is low. After `supply_ok` returns high, `rst_n_o` stays low for RST_DUR further ticks. This also applies at power-on.
- R9: The behaviour strap `rmode_sel` (0 selects behaviour 1, 1 selects behaviour 2) takes effect only while reset is high. In behaviour 1, `wd_ok_o` is always high.
- R10: Period counting advances only on cycles where `tick_ms` is high.
- R11: Writes while `rst_n_o` is low are ignored and leave the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle time-base strobe, one per tick |
| supply_ok | input | 1 | Supply within range |
| rmode_sel | input | 1 | Reset behaviour strap, sampled during reset |
| wr_en | input | 1 | Register write strobe (service attempt) |
| wr_data | input | 3 | Bit 2: timeout operation; bits 1:0: period code |
| rst_n_o | output | 1 | Active-low host reset |
| wd_ok_o | output | 1 | High while no unserviced expiry is pending |

## Verification
The bound checker checks several behaviours on every cycle. A closed-window write is followed by reset, and a qualified write keeps the host out of reset with the status high. An expiry produces the correct reaction for each reset behaviour, a low supply forces reset, and the configuration cannot change while reset is low. Some behaviours only the bench scenarios can show: the exact length of each period code, the exact stretch length after an expiry or a supply return, that counting pauses without ticks, and that the status stays low across repeated expiries. The bench sweeps all four codes in both operating modes and probes the window edges at floor(P/2)-1, floor(P/2) and P-1.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_PULSE = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic       timeout_mode;
        logic [1:0] per_code;
    } wdg_cfg_t;

    localparam int unsigned CFG_W = 3;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  wdg_cfg_t wdata,
    output wdg_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.timeout_mode <= 1'b0;
            cfg.per_code     <= 2'd0;
        end else if (we) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/wdg_window_timer.sv
module wdg_window_timer
    import wdg_pkg::*;
#(
    parameter int unsigned P0 = 10,
    parameter int unsigned P1 = 45,
    parameter int unsigned P2 = 100,
    parameter int unsigned P3 = 350
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic       tick,
    input  logic [1:0] per_code,
    output logic       win_closed,
    output logic       expire
);

    localparam int unsigned PMAX  = max4(P0, P1, P2, P3);
    localparam int unsigned CNT_W = $clog2(PMAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] half;

    always_comb begin
        case (per_code)
            2'd0:    period = CNT_W'(P0);
            2'd1:    period = CNT_W'(P1);
            2'd2:    period = CNT_W'(P2);
            default: period = CNT_W'(P3);
        endcase
        half = period >> 1;
    end

    assign win_closed = (cnt < half);
    assign expire     = run && tick && (cnt == period - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || restart || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdg_reset_ctrl.sv
module wdg_reset_ctrl
    import wdg_pkg::*;
#(
    parameter int unsigned RST_DUR = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_ok,
    input  logic rmode_sel,
    input  logic wr_en,
    input  logic timeout_mode,
    input  logic win_closed,
    input  logic expire,
    output logic run,
    output logic clear_ok,
    output logic rmode2,
    output logic rst_n_o,
    output logic wd_ok_o
);

    localparam int unsigned    RC_W    = $clog2(RST_DUR + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_DUR - 1);

    sup_state_e      state;
    logic [RC_W-1:0] rcnt;
    logic            wd_ok_q;

    assign run      = (state == ST_RUN);
    assign clear_ok = run && wr_en && (timeout_mode || !win_closed);
    assign rst_n_o  = run;
    assign wd_ok_o  = wd_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HOLD;
            rcnt    <= '0;
            wd_ok_q <= 1'b1;
            rmode2  <= rmode_sel;
        end else if (!supply_ok) begin
            state   <= ST_HOLD;
            rcnt    <= '0;
            wd_ok_q <= 1'b1;
        end else begin
            case (state)
                ST_HOLD: begin
                    state <= ST_PULSE;
                    rcnt  <= '0;
                end
                ST_PULSE: begin
                    if (tick) begin
                        if (rcnt == RC_LAST) begin
                            state <= ST_RUN;
                            rcnt  <= '0;
                        end else begin
                            rcnt <= rcnt + RC_W'(1);
                        end
                    end
                end
                ST_RUN: begin
                    if (wr_en && !clear_ok) begin
                        state <= ST_PULSE;
                        rcnt  <= '0;
                    end else if (clear_ok) begin
                        wd_ok_q <= 1'b1;
                    end else if (expire) begin
                        if (rmode2) begin
                            wd_ok_q <= 1'b0;
                        end else begin
                            state <= ST_PULSE;
                            rcnt  <= '0;
                        end
                    end
                end
                default: begin
                    state <= ST_HOLD;
                    rcnt  <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int unsigned P0      = 10,
    parameter int unsigned P1      = 45,
    parameter int unsigned P2      = 100,
    parameter int unsigned P3      = 350,
    parameter int unsigned RST_DUR = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_ms,
    input  logic             supply_ok,
    input  logic             rmode_sel,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             rst_n_o,
    output logic             wd_ok_o
);

    wdg_cfg_t cfg;
    wdg_cfg_t wr_cfg;
    logic     run;
    logic     clear_ok;
    logic     win_closed;
    logic     expire;
    logic     rmode2;

    assign wr_cfg = wdg_cfg_t'(wr_data);

    wdg_cfg_reg cfg_i (
        .clk   (clk),
        .rst   (rst),
        .we    (run && wr_en),
        .wdata (wr_cfg),
        .cfg   (cfg)
    );

    wdg_window_timer #(
        .P0 (P0), .P1 (P1), .P2 (P2), .P3 (P3)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .restart    (clear_ok),
        .tick       (tick_ms),
        .per_code   (cfg.per_code),
        .win_closed (win_closed),
        .expire     (expire)
    );

    wdg_reset_ctrl #(
        .RST_DUR (RST_DUR)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick_ms),
        .supply_ok    (supply_ok),
        .rmode_sel    (rmode_sel),
        .wr_en        (wr_en),
        .timeout_mode (cfg.timeout_mode),
        .win_closed   (win_closed),
        .expire       (expire),
        .run          (run),
        .clear_ok     (clear_ok),
        .rmode2       (rmode2),
        .rst_n_o      (rst_n_o),
        .wd_ok_o      (wd_ok_o)
    );

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       wr_en,
    input logic       rst_n_o,
    input logic       wd_ok_o,
    input logic       closed,
    input logic       expire,
    input logic       timeout_mode,
    input logic [1:0] per_code,
    input logic       rmode2
);

    // R4
    closed_write_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && supply_ok && wr_en && !timeout_mode && closed) |=> !rst_n_o);

    // R5
    valid_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && supply_ok && wr_en && (timeout_mode || !closed)) |=> (rst_n_o && wd_ok_o));

    // R6
    mode1_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && !rmode2 && expire && !wr_en) |=> !rst_n_o);

    // R7
    mode2_expire_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_n_o && supply_ok && rmode2 && expire && !wr_en) |=> (rst_n_o && !wd_ok_o));

    // R8
    supply_low_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !rst_n_o);

    // R9
    mode1_status_chk: assert property (@(posedge clk) disable iff (rst)
        !rmode2 |-> wd_ok_o);

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_n_o |=> $stable({timeout_mode, per_code}));

endmodule

bind wdg_supervisor wdg_supervisor_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .wr_en        (wr_en),
    .rst_n_o      (rst_n_o),
    .wd_ok_o      (wd_ok_o),
    .closed       (win_closed),
    .expire       (expire),
    .timeout_mode (cfg.timeout_mode),
    .per_code     (cfg.per_code),
    .rmode2       (rmode2)
);

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb_top;

    localparam int RST_DUR = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_ms = 1'b1;
    logic       supply_ok = 1'b1;
    logic       rmode_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = 3'd0;
    logic       rst_n_o;
    logic       wd_ok_o;

    int checks = 0;
    int errors = 0;
    int cur_to = 0;
    int cur_code = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdg_supervisor #(.RST_DUR(RST_DUR)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_ms   (tick_ms),
        .supply_ok (supply_ok),
        .rmode_sel (rmode_sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rst_n_o   (rst_n_o),
        .wd_ok_o   (wd_ok_o)
    );

    function automatic int per(input int code);
        case (code)
            0: return 10;
            1: return 45;
            2: return 100;
            default: return 350;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!rst_n_o && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (rst_n_o && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sys_reset(input logic mode);
        int n;
        rst       = 1'b1;
        rmode_sel = mode;
        idle(3);
        check("R1 rst_n during reset", int'(rst_n_o), 0);
        check("R1 wd_ok during reset", int'(wd_ok_o), 1);
        rst = 1'b0;
        @(negedge clk);
        count_low(n);
        check("R8 power-on stretch", n, RST_DUR);
        cur_to   = 0;
        cur_code = 0;
    endtask

    // starts and ends at tick 0 of a period
    task automatic configure(input int to, input int code);
        if (cur_to == 0) idle(per(cur_code) / 2);
        wr(3'(to * 4 + code));
        cur_to   = to;
        cur_code = code;
    endtask

    initial begin
        int n;
        int p;
        int h;
        logic [2:0] d;

        @(negedge clk);
        sys_reset(1'b0);

        // R1: default window, code 0 -> write at tick 1 is closed
        idle(1);
        wr(3'd0);
        check("R1 default window closed", int'(rst_n_o), 0);
        count_low(n);
        check("R6 stretch after closed write", n, RST_DUR);

        // window sweep
        for (int c = 0; c < 4; c++) begin
            configure(0, c);
            p = per(c);
            h = p / 2;
            d = 3'(c);
            idle(h - 1);
            wr(d);
            check("R4 write at last closed tick", int'(rst_n_o), 0);
            count_low(n);
            check("R6 stretch length", n, RST_DUR);
            idle(h);
            wr(d);
            check("R5 first open tick rst_n", int'(rst_n_o), 1);
            check("R5 first open tick wd_ok", int'(wd_ok_o), 1);
            idle(p - 1);
            wr(d);
            check("R5 last open tick", int'(rst_n_o), 1);
            count_high(n);
            check("R2 window period length", n, p);
            count_low(n);
            check("R6 expiry stretch", n, RST_DUR);
        end

        // timeout sweep
        for (int c = 0; c < 4; c++) begin
            configure(1, c);
            p = per(c);
            d = 3'(4 + c);
            wr(d);
            check("R3 write at tick 0", int'(rst_n_o), 1);
            idle(p - 1);
            wr(d);
            check("R3 write at last tick", int'(rst_n_o), 1);
            count_high(n);
            check("R2 timeout period length", n, p);
            if (c == 3) begin
                // R11: write during the reset stretch must be dropped
                wr(3'd0);
                while (!rst_n_o) @(negedge clk);
                wr(3'd7);
                check("R11 cfg kept through reset write", int'(rst_n_o), 1);
                count_high(n);
                check("R11 period still code 3", n, 350);
            end
            count_low(n);
            check("R6 timeout expiry stretch", n, RST_DUR - ((c == 3) ? 0 : 0));
        end

        // R10: no ticks -> no progress
        tick_ms = 1'b0;
        idle(1000);
        check("R10 no expiry without ticks", int'(rst_n_o), 1);
        tick_ms = 1'b1;
        count_high(n);
        check("R10 count resumes at zero", n, 350);
        count_low(n);

        // R9: strap change outside reset has no effect
        rmode_sel = 1'b1;
        count_high(n);
        check("R9 behaviour 1 kept after strap change", n, 350);
        check("R9 wd_ok high in behaviour 1", int'(wd_ok_o), 1);
        count_low(n);

        // R8: supply drop
        idle(20);
        supply_ok = 1'b0;
        @(negedge clk);
        check("R8 reset on supply drop", int'(rst_n_o), 0);
        idle(10);
        check("R8 reset held while supply low", int'(rst_n_o), 0);
        supply_ok = 1'b1;
        @(negedge clk);
        count_low(n);
        check("R8 stretch after supply return", n, RST_DUR);

        // behaviour 2
        sys_reset(1'b1);
        idle(9);
        check("R7 status before expiry", int'(wd_ok_o), 1);
        @(negedge clk);
        check("R7 status drops", int'(wd_ok_o), 0);
        check("R7 no reset on expiry", int'(rst_n_o), 1);
        idle(10);
        check("R7 status sticky", int'(wd_ok_o), 0);
        check("R7 still out of reset", int'(rst_n_o), 1);
        idle(5);
        wr(3'd0);
        check("R7 valid clear restores status", int'(wd_ok_o), 1);
        idle(1);
        wr(3'd0);
        check("R4 closed write in behaviour 2", int'(rst_n_o), 0);
        count_low(n);
        check("R6 stretch in behaviour 2", n, RST_DUR);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule